// File: doc/BRIEF.md
# Subnormal-Operand Floating-Point Multiplier

This block forms the product of two binary32 words in the case where at least one of them is subnormal. Such operations are usually trapped and handled slowly elsewhere. A start pulse latches the two operands. The block first orders them so that the subnormal one is taken first. It then forms the raw integer product of the two mantissas and searches for the leading one, one bit per clock. From that position it derives the result exponent and packs a normal, subnormal or zero result, keeping only the bits that fit. A one-cycle done pulse marks the result.

Rounding, NaN and infinity handling and status flags are left out on purpose. The block truncates the product and trusts the caller to route only the cases it covers. The word layout is parameterised: `EXP_W` exponent bits and `FRAC_W` fraction bits. The defaults of 8 and 23 give binary32.

Top module: `dnm_fmul`

## Requirements
- R1: When the second operand (after ordering) has a zero exponent field, or the first operand's magnitude (bits other than the sign) is zero, the result magnitude is zero.
- R2: When operand A's exponent field is nonzero, the operands are swapped so that B is taken first and A second. Otherwise A is first and B is second.
- R3: The result sign bit (the top bit) is always the XOR of the two input sign bits, zero results included.
- R4: Only the second operand's exponent field is used. The first operand contributes its FRAC_W fraction bits with no hidden bit. The second operand contributes its fraction with a hidden one at bit FRAC_W. A zero mantissa product yields a zero magnitude.
- R5: Let w be the bit index of the product's most significant one, and let BIAS be 2^(EXP_W-1)-1. The result exponent is e = (second exponent field) + w - (2*FRAC_W + BIAS - 1), which is 172 subtracted for binary32.
- R6: When e > 0, the fraction field (the low FRAC_W bits) holds the product shifted right by w-FRAC_W, and the exponent field holds e.
- R7: When e <= 0 and e + FRAC_W - 1 >= 0, the exponent field is zero and the fraction field holds the product shifted right by w - (FRAC_W-1) - e.
- R8: When e + FRAC_W - 1 < 0, the magnitude is flushed to zero.
- R9: done_o is high for exactly one cycle per accepted operation. result_o changes only at that cycle and holds its value until the next done.
- R10: A start_i pulse that arrives while an operation is in progress is ignored. It produces no extra done and does not alter the result.
- R11: done_o rises at most 2*FRAC_W+1 cycles after the clock edge that accepts start_i.
- R12: No rounding is applied. Product bits below the kept fraction are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch operands and begin, when idle |
| op_a_i | input | 1+EXP_W+FRAC_W | Operand A |
| op_b_i | input | 1+EXP_W+FRAC_W | Operand B |
| result_o | output | 1+EXP_W+FRAC_W | Truncated product |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds two instances. The first uses a tiny format of EXP_W=3 and FRAC_W=2, a 6-bit word, where all 4096 operand pairs can be applied. This reaches every swap decision, both zero shortcuts, each flush boundary and every shift distance of the subnormal path. The second uses the default binary32 layout. It runs directed extremes and a pseudo-random sweep with one subnormal operand, and it is also used to pulse start during a long leading-one search.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/dnm_order.sv
module dnm_order #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [FRAC_W-1:0] mant_x_o,
  output logic [FRAC_W:0]   mant_y_o,
  output logic [EXP_W-1:0]  exp_y_o,
  output logic              sign_o,
  output logic              zero_o
);
  logic              swap;
  logic [WORD_W-2:0] mag_x, mag_y;

  // a normal A goes second
  assign swap  = |op_a_i[WORD_W-2:FRAC_W];
  assign mag_x = swap ? op_b_i[WORD_W-2:0] : op_a_i[WORD_W-2:0];
  assign mag_y = swap ? op_a_i[WORD_W-2:0] : op_b_i[WORD_W-2:0];

  assign sign_o   = op_a_i[WORD_W-1] ^ op_b_i[WORD_W-1];
  assign exp_y_o  = mag_y[WORD_W-2:FRAC_W];
  assign mant_x_o = mag_x[FRAC_W-1:0];
  assign mant_y_o = {1'b1, mag_y[FRAC_W-1:0]};
  assign zero_o   = (exp_y_o == '0) || (mag_x == '0);
endmodule

// File: rtl/dnm_scan.sv
module dnm_scan
  import dnm_pkg::*;
#(
  parameter int PROD_W = 47,
  localparam int IDX_W = $clog2(PROD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              zero_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [PROD_W-1:0] norm_o,
  output logic [IDX_W-1:0]  lead_o,
  output logic              zero_o
);
  scan_state_e       state_q;
  logic [PROD_W-1:0] norm_q;
  logic [IDX_W-1:0]  lead_q;
  logic              zero_q;

  assign busy_o = (state_q == ST_SCAN);
  assign fin_o  = busy_o && (zero_q || norm_q[PROD_W-1]);
  assign norm_o = norm_q;
  assign lead_o = lead_q;
  assign zero_o = zero_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      norm_q  <= '0;
      lead_q  <= '0;
      zero_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_i) begin
          norm_q  <= prod_i;
          lead_q  <= IDX_W'(PROD_W - 1);
          zero_q  <= zero_i || (prod_i == '0);
          state_q <= ST_SCAN;
        end
        default: if (fin_o) begin
          state_q <= ST_IDLE;
        end else begin
          norm_q <= norm_q << 1;
          lead_q <= lead_q - IDX_W'(1);
        end
      endcase
    end
  end

  // cycles spent in the current search, checker only
  logic [IDX_W:0] scan_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   scan_cnt_q <= '0;
    else if (!busy_o)              scan_cnt_q <= '0;
    else if (scan_cnt_q != '1)     scan_cnt_q <= scan_cnt_q + 1'b1;
  end

  p_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !fin_o |=> busy_o && (lead_q == $past(lead_q) - IDX_W'(1)));

  p_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(scan_cnt_q) < PROD_W));
endmodule

// File: rtl/dnm_pack.sv
module dnm_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int PROD_W = 2 * FRAC_W + 1,
  localparam int IDX_W  = $clog2(PROD_W),
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [PROD_W-1:0] norm_i,
  input  logic [IDX_W-1:0]  lead_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic              zero_i,
  output logic [WORD_W-1:0] result_o
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OFFSET = 2 * FRAC_W + BIAS - 1;

  int                e_i;
  int                neg;
  logic [FRAC_W-1:0] frac_n, frac_s;
  logic [WORD_W-2:0] mag;

  always_comb begin
    e_i    = int'(exp_i) + int'(lead_i) - OFFSET;
    neg    = -e_i;
    // norm_i has its leading one at the top bit
    frac_n = FRAC_W'(norm_i >> (PROD_W - 1 - FRAC_W));
    frac_s = FRAC_W'((norm_i >> (PROD_W - FRAC_W)) >> neg);
    if (zero_i)                     mag = '0;
    else if (e_i > 0)               mag = {EXP_W'(e_i), frac_n};
    else if (e_i + FRAC_W - 1 >= 0) mag = {{EXP_W{1'b0}}, frac_s};
    else                            mag = '0;
    result_o = {sign_i, mag};
  end
endmodule

// File: rtl/dnm_fmul.sv
module dnm_fmul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o
);
  localparam int PROD_W = 2 * FRAC_W + 1;
  localparam int IDX_W  = $clog2(PROD_W);

  logic [FRAC_W-1:0] mant_x;
  logic [FRAC_W:0]   mant_y;
  logic [EXP_W-1:0]  exp_y, exp_q;
  logic              sign_c, sign_q, zero_c;
  logic [PROD_W-1:0] prod_c, norm;
  logic [IDX_W-1:0]  lead;
  logic              busy, fin, zero_s, accept;
  logic [WORD_W-1:0] packed_res;

  dnm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .mant_x_o(mant_x),
    .mant_y_o(mant_y),
    .exp_y_o (exp_y),
    .sign_o  (sign_c),
    .zero_o  (zero_c)
  );

  assign prod_c = PROD_W'(mant_x) * PROD_W'(mant_y);
  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= '0;
      sign_q <= 1'b0;
    end else if (accept) begin
      exp_q  <= exp_y;
      sign_q <= sign_c;
    end
  end

  dnm_scan #(.PROD_W(PROD_W)) u_scan (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .prod_i(prod_c),
    .zero_i(zero_c),
    .busy_o(busy),
    .fin_o (fin),
    .norm_o(norm),
    .lead_o(lead),
    .zero_o(zero_s)
  );

  dnm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .norm_i  (norm),
    .lead_i  (lead),
    .exp_i   (exp_q),
    .sign_i  (sign_q),
    .zero_i  (zero_s),
    .result_o(packed_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) result_o <= packed_res;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy && (sign_q == ($past(op_a_i[WORD_W-1]) ^ $past(op_b_i[WORD_W-1]))));
endmodule

// File: tb/dnm_fmul_tb.sv
`timescale 1ns/1ps
module dnm_fmul_tb;
  localparam int SE = 3, SF = 2, SW = 1 + SE + SF;
  localparam int FE = 8, FF = 23, FW = 1 + FE + FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          st_s = 1'b0, st_f = 1'b0;
  logic [SW-1:0] a_s = '0, b_s = '0, r_s;
  logic [FW-1:0] a_f = '0, b_f = '0, r_f;
  logic          d_s, d_f;

  dnm_fmul #(.EXP_W(SE), .FRAC_W(SF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_s),
    .op_a_i(a_s), .op_b_i(b_s), .result_o(r_s), .done_o(d_s));

  dnm_fmul #(.EXP_W(FE), .FRAC_W(FF)) u_dut_full (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_f),
    .op_a_i(a_f), .op_b_i(b_f), .result_o(r_f), .done_o(d_f));

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  // R1..R8, R12: arithmetic model from the requirements
  function automatic longint model(longint a, longint b, int ew, int fw);
    int     ww = 1 + ew + fw;
    longint fm = (64'sd1 << fw) - 1;
    longint em = (64'sd1 << ew) - 1;
    longint mm = (64'sd1 << (ww - 1)) - 1;
    longint x, y, sgn, ey, p, n, mag;
    int     w, e, bias;
    bit     swap;
    swap = ((a >> fw) & em) != 0;
    x = swap ? b : a;
    y = swap ? a : b;
    sgn = ((a ^ b) >> (ww - 1)) & 1;
    ey = (y >> fw) & em;
    if (ey == 0 || (x & mm) == 0) return sgn << (ww - 1);
    p = (x & fm) * ((y & fm) | (64'sd1 << fw));
    if (p == 0) return sgn << (ww - 1);
    w = -1; n = p;
    while (n != 0) begin n = n >> 1; w++; end
    bias = (1 << (ew - 1)) - 1;
    e = int'(ey) + w - (2 * fw + bias - 1);
    if (e > 0)               mag = ((p >> (w - fw)) & fm) | ((longint'(e) & em) << fw);
    else if (e + fw - 1 >= 0) mag = (p >> (w - (fw - 1) - e)) & fm;
    else                     mag = 0;
    return (sgn << (ww - 1)) | mag;
  endfunction

  task automatic op_small(int a, int b);
    int lat = 0;
    @(negedge clk); a_s = SW'(a); b_s = SW'(b); st_s = 1'b1;
    @(negedge clk); st_s = 1'b0; lat = 1;
    while (!d_s && lat < 200) begin @(negedge clk); lat++; end
    if (lat > 2 * SF + 2) check("R11 latency small", lat, 2 * SF + 2);
    check("R1-8 small result", longint'(r_s), model(a, b, SE, SF));
    @(negedge clk);
    check("R9 done pulse small", longint'(d_s), 0);
  endtask

  task automatic op_full(longint a, longint b, string req);
    int lat = 0;
    @(negedge clk); a_f = FW'(a); b_f = FW'(b); st_f = 1'b1;
    @(negedge clk); st_f = 1'b0; lat = 1;
    while (!d_f && lat < 200) begin @(negedge clk); lat++; end
    check("R11 latency full", longint'(lat <= 2 * FF + 2), 1);
    check(req, longint'(r_f), model(a, b, FE, FF));
  endtask

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] nxt(logic [31:0] v);
    logic [31:0] t = v;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset done", longint'(d_s), 0);
    check("R9 reset result", longint'(r_f), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive tiny format: R1 R2 R3 R4 R5 R6 R7 R8 R12
    for (int a = 0; a < (1 << SW); a++)
      for (int b = 0; b < (1 << SW); b++)
        op_small(a, b);

    // directed binary32
    op_full(64'h0000_0001, 64'h3f80_0000, "R7 smallest times one");
    check("R7 exact value", longint'(r_f), 64'h0000_0001);
    op_full(64'h8000_0001, 64'h3f00_0000, "R8 flush half");
    check("R8 exact value", longint'(r_f), 64'h8000_0000);
    op_full(64'h3f80_0000, 64'h0040_0000, "R2 swapped order");
    check("R2 exact value", longint'(r_f), 64'h0040_0000);
    op_full(64'h0040_0000, 64'h4800_0000, "R6 normal result");
    op_full(64'h007f_ffff, 64'h7f7f_ffff, "R12 truncation");
    op_full(64'h0000_0000, 64'hc000_0000, "R1 zero first");
    check("R3 zero sign", longint'(r_f), 64'h8000_0000);
    op_full(64'h0012_3456, 64'h8065_4321, "R1 both subnormal");
    op_full(64'h4000_0000, 64'h3f80_0000, "R4 zero product");

    // pseudo-random, one subnormal operand
    for (int i = 0; i < 300; i++) begin
      longint a, b;
      rs = nxt(rs); a = longint'(rs);
      rs = nxt(rs); b = longint'(rs);
      if (i % 2 == 0) a = a & 64'h807f_ffff;
      else            b = b & 64'h807f_ffff;
      op_full(a, b, "R5 random");
    end

    // R10: start during a long search is ignored
    begin
      int lat = 0;
      int extra = 0;
      @(negedge clk); a_f = 32'h0000_0001; b_f = 32'h3f80_0000; st_f = 1'b1;
      @(negedge clk); st_f = 1'b0;
      @(negedge clk); a_f = 32'h0040_0000; b_f = 32'h4800_0000; st_f = 1'b1;
      @(negedge clk); st_f = 1'b0; lat = 3;
      while (!d_f && lat < 200) begin @(negedge clk); lat++; end
      check("R10 first result kept", longint'(r_f), 64'h0000_0001);
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (d_f) extra++;
      end
      check("R10 no extra done", extra, 0);
      check("R9 result held", longint'(r_f), 64'h0000_0001);
    end

    finish_run();
  end
endmodule